// File: doc/BRIEF.md
# Serial Channel with Three-Entry Receive Buffer

This block is one full-duplex asynchronous serial channel. A single holding register takes characters from the host and passes each one to a shifter, which drives the line. Each frame is sent in this order:

- one low start bit
- the data bits, least significant first
- an optional parity bit
- one high stop bit

The receiver finds a start bit and shifts in the frame. It then puts the character, together with its error flags, into a three-entry first-in first-out buffer. The shifter acts as a fourth stage when that buffer is full.

Bit timing comes from one of two sources. The first is a 16x tick supplied by an external baud generator. The second is a pair of 1x clocks sampled in the block's clock domain. In 1x mode the transmitter moves on a falling edge and the receiver samples on a rising edge. Each direction has its own enable. A local loop routes the transmit shifter into the receiver and holds the outgoing line high. Status outputs report:

- space in the holding register
- an empty transmitter
- buffered data
- a full buffer
- a sticky overrun

Top module: `uart_chan`

## Requirements
- R1: After reset, txd is high, tx_rdy and tx_empty are 1, and rx_rdy, rx_full and rx_ovr are 0.
- R2: A transmitted frame consists of a low start bit, DW data bits sent LSB first, a parity bit only if par_en is 1, and a high stop bit. When ext_sel is 0, every bit lasts OVS ticks of tick16.
- R3: The parity bit is the XOR of the data bits when par_odd is 0 and its inverse when par_odd is 1. A received parity bit that does not match sets rx_perr for that character.
- R4: txd stays high while tx_en is 0 and while the transmitter is idle. Characters written while tx_en is 0 wait in the holding register.
- R5: When ext_sel is 0, a low receive line is accepted as a start bit only if it is still low OVS/2 ticks after it was first seen. A shorter low pulse produces no character. Each later bit is sampled OVS ticks after the previous one.
- R6: Received characters appear on rx_dout in arrival order. rx_rd removes the head entry.
- R7: rx_rdy is 1 whenever the buffer holds at least one character. rx_full is 1 when it holds three.
- R8: With three characters buffered, a fourth character waits in the receive shifter. A fifth character arriving before space frees replaces the waiting one and sets rx_ovr. rx_ovr stays set until rx_en goes low.
- R9: A stop bit sampled low sets rx_ferr for that character.
- R10: tx_rdy is 1 exactly when the holding register is empty. tx_empty is 1 only when both the holding register and the shifter are idle. A write while tx_rdy is 0 is ignored.
- R11: When ext_sel is 1, txd changes only in the cycle after ext_txc falls. The receiver takes a sample on each rising edge of ext_rxc, and the first low sample it sees is the start bit.
- R12: When loopback is 1, the receiver gets the transmit shifter's output, rxd is ignored, and txd stays high.
- R13: A read and a character push in the same cycle both take effect: the old head leaves and the new character is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Oversampling tick (OVS per bit) |
| ext_sel | input | 1 | 1: use ext_txc/ext_rxc as 1x bit clocks |
| ext_txc | input | 1 | External transmit bit clock (falling edge active) |
| ext_rxc | input | 1 | External receive bit clock (rising edge active) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low clears overrun |
| loopback | input | 1 | Local loop: transmitter feeds receiver |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1 |
| tx_wr | input | 1 | Write tx_data into holding register |
| tx_data | input | DW | Character to send |
| tx_rdy | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter empty |
| txd | output | 1 | Serial output, high = mark |
| rxd | input | 1 | Serial input, high = mark |
| rx_rd | input | 1 | Pop the head character |
| rx_dout | output | DW | Head character |
| rx_ferr | output | 1 | Framing error of head character |
| rx_perr | output | 1 | Parity error of head character |
| rx_rdy | output | 1 | Buffer not empty |
| rx_full | output | 1 | Buffer holds three characters |
| rx_ovr | output | 1 | Sticky overrun |

## Verification
The pairing that matters most is a host read and the push of a just-completed character landing in the same clock edge. If that edge is handled wrongly, either the new character is lost or the old head is not removed.

The bench creates this case as follows:

1. It leaves one character in the buffer.
2. It sends a second character.
3. It fires a single rx_rd pulse at each offset in a window of cycles around the end of that frame, one offset per run.

For every offset, the bench checks three things:

- the head seen at the read is the old character
- exactly one entry remains afterwards
- that entry is the new character

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

    typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_PAR, TX_STOP} tx_st_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_e;

    // Parity bit for a reduced data XOR; odd selects odd parity.
    function automatic logic par_bit(input logic data_xor, input logic odd);
        return data_xor ^ odd;
    endfunction

endpackage

// File: rtl/uart_chan_fifo.sv
module uart_chan_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (push) begin
            d.mem[q.wp] = pdata;
            d.wp        = nxt(q.wp);
        end
        if (pop) d.rp = nxt(q.rp);
        d.cnt = q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign head  = q.mem[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
endmodule

// File: rtl/uart_chan_tx.sv
module uart_chan_tx
    import uart_chan_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic          ext,
    input  logic          ext_fall,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          line,
    output logic          rdy,
    output logic          empty
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam int CW = $clog2(OVS);

    typedef struct packed {
        tx_st_e        st;
        logic [DW-1:0] thr;
        logic          thr_v;
        logic [DW-1:0] sh;
        logic          par;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
        logic          line;
    } tx_t;

    tx_t  q, d;
    logic step;

    always_comb begin
        d = q;
        if (tick && !ext) d.cnt = q.cnt + 1'b1;
        step = ext ? ext_fall : (tick && q.cnt == CW'(OVS - 1));
        if (wr && !q.thr_v) begin
            d.thr   = wdata;
            d.thr_v = 1'b1;
        end
        if (!en) begin
            d.st   = TX_IDLE;
            d.line = 1'b1;
        end else if (step) begin
            case (q.st)
                TX_IDLE: begin
                    d.line = 1'b1;
                    if (q.thr_v) begin
                        d.line  = 1'b0;
                        d.sh    = q.thr;
                        d.par   = par_bit(^q.thr, par_odd);
                        d.thr_v = 1'b0;
                        d.idx   = '0;
                        d.st    = TX_DATA;
                    end
                end
                TX_DATA: begin
                    d.line = q.sh[0];
                    d.sh   = q.sh >> 1;
                    d.idx  = q.idx + 1'b1;
                    if (q.idx == IW'(DW - 1)) d.st = par_en ? TX_PAR : TX_STOP;
                end
                TX_PAR: begin
                    d.line = q.par;
                    d.st   = TX_STOP;
                end
                default: begin
                    d.line = 1'b1;
                    d.st   = TX_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.st   <= TX_IDLE;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line  = q.line;
    assign rdy   = !q.thr_v;
    assign empty = !q.thr_v && (q.st == TX_IDLE);
endmodule

// File: rtl/uart_chan_rx.sv
module uart_chan_rx
    import uart_chan_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic          ext,
    input  logic          ext_rise,
    input  logic          rin,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          ready,
    output logic          push,
    output logic [DW+1:0] push_data,
    output logic          ovr
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam int CW = $clog2(OVS);

    typedef struct packed {
        rx_st_e        st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          perr;
        logic          pend;
        logic [DW+1:0] pdata;
        logic          ovr;
    } rx_t;

    rx_t  q, d;
    logic step;
    logic done;

    always_comb begin
        d    = q;
        done = 1'b0;
        push = q.pend && ready;
        if (push) d.pend = 1'b0;
        if (tick && !ext) d.cnt = q.cnt + 1'b1;
        step = ext ? ext_rise : (tick && q.cnt == CW'(OVS - 1));
        if (!en) begin
            d.st  = RX_IDLE;
            d.ovr = 1'b0;
        end else begin
            case (q.st)
                RX_IDLE: begin
                    if (ext) begin
                        if (ext_rise && !rin) begin
                            d.st   = RX_DATA;
                            d.idx  = '0;
                            d.perr = 1'b0;
                        end
                    end else if (tick && !rin) begin
                        d.st   = RX_START;
                        d.cnt  = '0;
                        d.idx  = '0;
                        d.perr = 1'b0;
                    end
                end
                RX_START: begin
                    if (tick && q.cnt == CW'(OVS / 2 - 1)) begin
                        if (!rin) begin
                            d.st  = RX_DATA;
                            d.cnt = '0;
                        end else begin
                            d.st = RX_IDLE;
                        end
                    end
                end
                RX_DATA: begin
                    if (step) begin
                        d.sh  = {rin, q.sh[DW-1:1]};
                        d.idx = q.idx + 1'b1;
                        if (q.idx == IW'(DW - 1)) d.st = par_en ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    if (step) begin
                        d.perr = (rin != par_bit(^q.sh, par_odd));
                        d.st   = RX_STOP;
                    end
                end
                default: begin
                    if (step) begin
                        done = 1'b1;
                        d.st = RX_IDLE;
                    end
                end
            endcase
        end
        if (done) begin
            d.pdata = {!rin, q.perr, q.sh};
            if (q.pend && !push) d.ovr = 1'b1;
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push_data = q.pdata;
    assign ovr       = q.ovr;
endmodule

// File: rtl/uart_chan.sv
module uart_chan #(
    parameter int DW    = 8,
    parameter int OVS   = 16,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick16,
    input  logic          ext_sel,
    input  logic          ext_txc,
    input  logic          ext_rxc,
    input  logic          tx_en,
    input  logic          rx_en,
    input  logic          loopback,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    output logic          tx_rdy,
    output logic          tx_empty,
    output logic          txd,
    input  logic          rxd,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_dout,
    output logic          rx_ferr,
    output logic          rx_perr,
    output logic          rx_rdy,
    output logic          rx_full,
    output logic          rx_ovr
);
    localparam int EW = DW + 2;

    typedef struct packed {
        logic txc;
        logic rxc;
        logic rin;
    } edge_t;

    edge_t         q, d;
    logic          tx_line;
    logic          txc_fall;
    logic          rxc_rise;
    logic          f_empty;
    logic          f_full;
    logic          f_pop;
    logic          f_push;
    logic [EW-1:0] f_in;
    logic [EW-1:0] f_head;

    always_comb begin
        d     = q;
        d.txc = ext_txc;
        d.rxc = ext_rxc;
        d.rin = loopback ? tx_line : rxd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.rin <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txc_fall = q.txc && !ext_txc;
    assign rxc_rise = !q.rxc && ext_rxc;
    assign f_pop    = rx_rd && !f_empty;

    uart_chan_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .en(tx_en), .tick(tick16), .ext(ext_sel),
        .ext_fall(txc_fall), .wr(tx_wr), .wdata(tx_data), .par_en(par_en),
        .par_odd(par_odd), .line(tx_line), .rdy(tx_rdy), .empty(tx_empty)
    );

    uart_chan_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .en(rx_en), .tick(tick16), .ext(ext_sel),
        .ext_rise(rxc_rise), .rin(q.rin), .par_en(par_en), .par_odd(par_odd),
        .ready(!f_full || f_pop), .push(f_push), .push_data(f_in), .ovr(rx_ovr)
    );

    uart_chan_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(f_push), .pdata(f_in), .pop(f_pop),
        .head(f_head), .empty(f_empty), .full(f_full)
    );

    assign txd     = loopback ? 1'b1 : tx_line;
    assign rx_dout = f_head[DW-1:0];
    assign rx_perr = f_head[DW];
    assign rx_ferr = f_head[DW+1];
    assign rx_rdy  = !f_empty;
    assign rx_full = f_full;
endmodule

// File: rtl/uart_chan_chk.sv
module uart_chan_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic rx_en,
    input logic loopback,
    input logic ext_sel,
    input logic ext_txc,
    input logic txd,
    input logic tx_wr,
    input logic tx_rdy,
    input logic tx_empty,
    input logic rx_rdy,
    input logic rx_full,
    input logic rx_ovr
);
    a_r4_mark_when_off: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> txd);

    a_r12_loop_mark: assert property (@(posedge clk) disable iff (rst)
        (loopback && $past(loopback)) |-> txd);

    a_r7_full_has_data: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> rx_rdy);

    a_r10_empty_has_room: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> tx_rdy);

    a_r10_write_taken: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_rdy) |=> (!tx_rdy && !tx_empty));

    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_en && $past(rx_en) && $past(rx_ovr)) |-> rx_ovr);

    a_r11_ext_tx_fall: assert property (@(posedge clk) disable iff (rst)
        (ext_sel && $past(ext_sel) && tx_en && $past(tx_en) && !loopback &&
         !$past(loopback) && (txd != $past(txd)))
        |-> ($past(ext_txc, 2) && !$past(ext_txc)));
endmodule

bind uart_chan uart_chan_chk u_chk (.*);

// File: tb/uart_chan_test.sv
module uart_chan_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst, tick16, ext_sel, ext_txc, ext_rxc, tx_en, rx_en, loopback;
    logic       par_en, par_odd, tx_wr, rxd, rx_rd;
    logic [7:0] tx_data, rx_dout;
    logic       tx_rdy, tx_empty, txd, rx_ferr, rx_perr, rx_rdy, rx_full, rx_ovr;

    int checks = 0;
    int fails  = 0;
    int ext_viol = 0;
    logic [8:0] ebits;
    int ecol;

    always #(CLK_P / 2) clk = ~clk;

    uart_chan uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] v, input logic odd);
        return (^v) ^ odd;
    endfunction

    task automatic rx_bit(input logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] v, input logic pe, input logic odd,
                           input logic bad_par, input logic bad_stop);
        rx_bit(1'b0);
        for (int i = 0; i < 8; i++) rx_bit(v[i]);
        if (pe) rx_bit(exp_par(v, odd) ^ bad_par);
        if (bad_stop) begin
            rxd = 1'b0;
            repeat (12) @(negedge clk);
            rxd = 1'b1;
            repeat (20) @(negedge clk);
        end else begin
            rx_bit(1'b1);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic write_tx(input logic [7:0] v);
        tx_data = v;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic pop(output logic [7:0] v, output logic fe, output logic pe);
        v  = rx_dout;
        fe = rx_ferr;
        pe = rx_perr;
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cap_tx(input logic pe, output logic [7:0] v, output logic p,
                          output logic stp, output logic got);
        int t = 0;
        v = '0; p = 1'b0; stp = 1'b0; got = 1'b0;
        while (txd !== 1'b0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t < 3000) begin
            got = 1'b1;
            repeat (8) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                repeat (16) @(negedge clk);
                v[i] = txd;
            end
            if (pe) begin
                repeat (16) @(negedge clk);
                p = txd;
            end
            repeat (16) @(negedge clk);
            stp = txd;
        end
    endtask

    task automatic wait_rx(input int lim);
        int t = 0;
        while (rx_rdy !== 1'b1 && t < lim) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic ext_run(input int n);
        logic last = txd;
        logic fell = 1'b0;
        logic started = 1'b0;
        ebits = '0;
        ecol  = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (txd !== last && !fell) ext_viol++;
            last = txd;
            fell = 1'b0;
            if (c % 16 == 0) begin
                ext_txc = 1'b0; ext_rxc = 1'b0; fell = 1'b1;
            end else if (c % 16 == 8) begin
                ext_txc = 1'b1; ext_rxc = 1'b1;
                if (started && ecol < 9) begin
                    ebits[ecol] = txd;
                    ecol++;
                end else if (!started && txd == 1'b0) begin
                    started = 1'b1;
                end
            end
        end
    endtask

    initial begin
        #(CLK_P * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, hv;
        logic fe, pe, p, stp, got;
        int   mark_bad;
        void'($urandom(32'd7321));
        rst = 1'b1; tick16 = 1'b1; ext_sel = 1'b0; ext_txc = 1'b1; ext_rxc = 1'b1;
        tx_en = 1'b0; rx_en = 1'b0; loopback = 1'b0; par_en = 1'b0; par_odd = 1'b0;
        tx_wr = 1'b0; tx_data = '0; rxd = 1'b1; rx_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 tx_rdy", tx_rdy, 1);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_rdy", rx_rdy, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 rx_ovr", rx_ovr, 0);

        // R4: disabled transmitter holds the character and the line at mark
        write_tx(8'hA5);
        chk("R10 tx_rdy after write", tx_rdy, 0);
        mark_bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) mark_bad++;
        end
        chk("R4 mark while disabled", mark_bad, 0);
        chk("R4 char held", tx_empty, 0);
        tx_en = 1'b1;
        cap_tx(1'b0, v, p, stp, got);
        chk("R2 frame seen", got, 1);
        chk("R2 data lsb first", v, 8'hA5);
        chk("R2 stop high", stp, 1);
        chk("R10 empty after frame", tx_empty, 1);

        // R10: second write while holding register full is dropped
        write_tx(8'h3E);
        write_tx(8'hC1);
        cap_tx(1'b0, v, p, stp, got);
        chk("R10 first char kept", v, 8'h3E);
        mark_bad = 0;
        repeat (400) begin
            @(negedge clk);
            if (txd !== 1'b1) mark_bad++;
        end
        chk("R10 dropped write, R4 idle mark", mark_bad, 0);

        // R3: transmit parity polarity
        par_en = 1'b1; par_odd = 1'b1;
        write_tx(8'h00);
        cap_tx(1'b1, v, p, stp, got);
        chk("R3 odd parity of 00", p, 1);
        par_odd = 1'b0;
        write_tx(8'h07);
        cap_tx(1'b1, v, p, stp, got);
        chk("R3 even parity of 07", p, 1);
        chk("R2 data with parity", v, 8'h07);

        // R12 + R6: random characters through the local loop, rxd held low
        rx_en = 1'b1; loopback = 1'b1; rxd = 1'b0;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] r = 8'($urandom);
            par_en  = 1'($urandom);
            par_odd = 1'($urandom);
            write_tx(r);
            mark_bad = 0;
            for (int t = 0; t < 3000 && rx_rdy !== 1'b1; t++) begin
                @(negedge clk);
                if (txd !== 1'b1) mark_bad++;
            end
            chk("R12 txd mark in loop", mark_bad, 0);
            pop(v, fe, pe);
            chk("R12 loop data", v, r);
            chk("R3 loop no perr", pe, 0);
            chk("R9 loop no ferr", fe, 0);
            repeat (20) @(negedge clk);
        end
        loopback = 1'b0; rxd = 1'b1;
        repeat (40) @(negedge clk);

        // R6: random characters on rxd
        for (int k = 0; k < 6; k++) begin
            logic [7:0] r = 8'($urandom);
            par_en  = 1'($urandom);
            par_odd = 1'($urandom);
            send_rx(r, par_en, par_odd, 1'b0, 1'b0);
            wait_rx(100);
            pop(v, fe, pe);
            chk("R6 rx data", v, r);
            chk("R6 rx clean perr", pe, 0);
        end

        // R3 bad parity, R9 bad stop
        par_en = 1'b1; par_odd = 1'b0;
        send_rx(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0);
        wait_rx(100);
        pop(v, fe, pe);
        chk("R3 perr set", pe, 1);
        chk("R3 data kept", v, 8'h5A);
        par_en = 1'b0;
        send_rx(8'h81, 1'b0, 1'b0, 1'b0, 1'b1);
        wait_rx(100);
        pop(v, fe, pe);
        chk("R9 ferr set", fe, 1);
        chk("R9 data kept", v, 8'h81);
        chk("R9 no extra char", rx_rdy, 0);

        // R5: short low pulse is not a start bit
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (250) @(negedge clk);
        chk("R5 glitch rejected", rx_rdy, 0);

        // R7 / R8: fill, overrun, drain
        send_rx(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 rdy with one", rx_rdy, 1);
        chk("R7 not full with one", rx_full, 0);
        send_rx(8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
        send_rx(8'h33, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 full with three", rx_full, 1);
        send_rx(8'h44, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 fourth no overrun", rx_ovr, 0);
        send_rx(8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 fifth overrun", rx_ovr, 1);
        pop(v, fe, pe); chk("R8 order 0", v, 8'h11);
        pop(v, fe, pe); chk("R8 order 1", v, 8'h22);
        pop(v, fe, pe); chk("R8 order 2", v, 8'h33);
        pop(v, fe, pe); chk("R8 replaced char", v, 8'h55);
        chk("R7 empty after drain", rx_rdy, 0);
        chk("R8 ovr sticky", rx_ovr, 1);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R8 ovr cleared", rx_ovr, 0);

        // R13: read pulse swept across the push of a new character
        for (int off = 140; off < 164; off++) begin
            send_rx(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
            fork
                send_rx(8'(off), 1'b0, 1'b0, 1'b0, 1'b0);
                begin
                    repeat (off) @(negedge clk);
                    hv = rx_dout;
                    rx_rd = 1'b1;
                    @(negedge clk);
                    rx_rd = 1'b0;
                end
            join
            repeat (10) @(negedge clk);
            chk("R13 old head read", hv, 8'h3C);
            chk("R13 one left", {rx_rdy, rx_full}, 2'b10);
            pop(v, fe, pe);
            chk("R13 new kept", v, off);
            chk("R13 drained", rx_rdy, 0);
        end

        // R11: external 1x clocks
        ext_sel = 1'b1; par_en = 1'b0;
        repeat (4) @(negedge clk);
        write_tx(8'h96);
        ext_run(16 * 14);
        chk("R11 tx data on 1x", ebits[7:0], 8'h96);
        chk("R11 tx stop on 1x", ebits[8], 1);
        chk("R11 txd only after fall", ext_viol, 0);
        loopback = 1'b1;
        write_tx(8'h6B);
        ext_run(16 * 14);
        chk("R11 rx on rising edge", rx_rdy, 1);
        pop(v, fe, pe);
        chk("R11 rx data", v, 8'h6B);
        chk("R11 rx ferr", fe, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule